// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Bus-Idle Monitor

This block watches the clock and data lines of a two-wire SMBus/I2C-style bus and reports two conditions to the surrounding serial interface. The first is a stuck clock. Once the clock line has stayed low longer than a programmed number of system-clock cycles, the block emits a single-cycle timeout pulse and sets a sticky interrupt flag. The second is bus idleness. Once both lines have stayed high for more than a fixed number of ticks from the SMBus clock source, the bus is reported free, and a master that is waiting to send a START receives a one-cycle permit strobe.

Both raw lines first pass through a two-stage synchronizer. A reload counter measures the clock-low time. It is loaded from `reload_val` while the synchronized clock is high and counts down only while it is low. Slave clock stretching therefore goes unnoticed unless it outlasts the limit. To meet the 25 ms rule, software sets `reload_val` to the system-clock frequency multiplied by 25 ms. The timeout service routine then resets the interface within the 10 ms allowance by dropping `lowto_en` and raising it again.

A separate idle counter advances only on `src_tick`. Free-bus detection therefore needs the clock source running, even when the device acts only as a slave.

The low-timeout engine has four states:
- `LT_OFF`: detection disabled.
- `LT_ARMED`: clock high, counter held at the reload value.
- `LT_COUNT`: clock low, counter running.
- `LT_EXPIRED`: timeout already reported, waiting for the clock to rise.

Its transitions are named arm, stretch-start, stretch-end, overflow, release and disable.

The idle engine has three states:
- `IB_BUSY`: a line is low, or detection is disabled.
- `IB_WAIT`: both lines are high and ticks are being counted.
- `IB_FREE`: the bus is free and the counter is saturated.

Its transitions are named settle, expire, activity and disable.

Top module: `smb_line_watch`

## Requirements
- R1: After reset, `lowto_pulse`, `lowto_flag`, `bus_free` and `start_go` are all 0, and both synchronized lines read high.
- R2: With `lowto_en` high and `reload_val` = N (N at least 1), `lowto_pulse` is high for one cycle in the (N+3)th rising clock edge counted from the first edge that samples `scl_in` low. Two of those edges are synchronizer delay, and the remaining N+1 edges see the synchronized clock low.
- R3: The counter is reloaded whenever the synchronized clock is high. A low phase seen on N or fewer edges raises no pulse, and the next low phase is timed from the full reload value again.
- R4: A single low phase produces at most one `lowto_pulse`, however long it lasts.
- R5: `lowto_flag` rises together with `lowto_pulse` and stays high until `flag_clr` is sampled high. A pulse on the same edge as `flag_clr` leaves the flag set.
- R6: While `lowto_en` is low, no pulse is raised. After `lowto_en` returns high during a low phase, the pulse comes on the (N+2)th edge counted from the first edge that samples the enable high.
- R7: With `freeto_en` high and both synchronized lines high, `bus_free` rises on the edge that samples the eleventh `src_tick` while waiting (IDLE_LIMIT+1 with the default of 10). Without ticks, `bus_free` never rises.
- R8: A low level on either synchronized line, including a START (data falling while clock is high), drops `bus_free` on the third edge after the raw line falls. It also restarts the tick count from zero.
- R9: Once free, further ticks keep `bus_free` high. The idle count saturates and does not wrap.
- R10: While `freeto_en` is low, `bus_free` is 0 and `start_go` never pulses. Clearing the enable drops `bus_free` on the next edge.
- R11: `start_go` is a one-cycle pulse. It comes in the cycle `bus_free` rises if `start_req` is already high, or one edge after `start_req` is raised while the bus is free. A request held high yields only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| src_tick | input | 1 | One-cycle tick from the SMBus clock source |
| lowto_en | input | 1 | Enables clock-low timeout detection |
| freeto_en | input | 1 | Enables bus-free detection |
| reload_val | input | CNT_W | Low-phase length, in system clocks, before timeout |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| start_req | input | 1 | Master has a START waiting for a free bus |
| lowto_pulse | output | 1 | One-cycle clock-low timeout event |
| lowto_flag | output | 1 | Sticky timeout interrupt flag |
| bus_free | output | 1 | Bus judged idle |
| start_go | output | 1 | One-cycle permit to issue the pending START |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an idle limit of 10 and two synchronizer stages. It drives `reload_val` at 20, so a timeout is reached in a few dozen cycles rather than the full 25 ms. It steps the tick input by hand, which lets the eleventh-tick boundary of the idle count be checked one tick before and one tick after. The short reload also brings within reach a stretch of exactly N low edges, a disable and re-enable in the middle of a low phase, a clear that lands on the overflow edge, and START/STOP activity against a free bus.

// File: rtl/smb_watch_pkg.sv
package smb_watch_pkg;

    typedef enum logic [1:0] {
        LT_OFF,
        LT_ARMED,
        LT_COUNT,
        LT_EXPIRED
    } low_state_t;

    typedef enum logic [1:0] {
        IB_BUSY,
        IB_WAIT,
        IB_FREE
    } idle_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    // Each line gets its own shift chain; idle bus level (high) at reset.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
        end

        assign synced[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer
    import smb_watch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl_s,
    input  logic [CNT_W-1:0] reload,
    input  logic             flag_clr,
    output logic             pulse,
    output logic             flag
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    low_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            LT_OFF: begin
                cnt_d = reload;
                if (en) state_d = LT_ARMED;            // arm
            end
            LT_ARMED: begin
                if (!en) begin
                    state_d = LT_OFF;                  // disable
                    cnt_d   = reload;
                end else if (!scl_s) begin
                    state_d = LT_COUNT;                // stretch-start
                    cnt_d   = reload - ONE;
                end else begin
                    cnt_d   = reload;
                end
            end
            LT_COUNT: begin
                if (!en) begin
                    state_d = LT_OFF;                  // disable
                    cnt_d   = reload;
                end else if (scl_s) begin
                    state_d = LT_ARMED;                // stretch-end
                    cnt_d   = reload;
                end else if (cnt_q == '0) begin
                    state_d = LT_EXPIRED;              // overflow
                    fire    = 1'b1;
                end else begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            LT_EXPIRED: begin
                if (!en) begin
                    state_d = LT_OFF;                  // disable
                    cnt_d   = reload;
                end else if (scl_s) begin
                    state_d = LT_ARMED;                // release
                    cnt_d   = reload;
                end
            end
            default: begin
                state_d = LT_OFF;
                cnt_d   = reload;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pulse <= fire;
            flag  <= fire | (flag & ~flag_clr);
        end
    end

    // R2: a timeout only follows an edge that saw the clock low while enabled
    p_pulse_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> ($past(!scl_s) && $past(en)));

    // R3: no pulse right after the counter was held with the clock high
    p_no_fire_when_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_ARMED && scl_s) |=> !pulse);

    // R4: one pulse per low phase
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R5: the flag accompanies every pulse and stays until cleared
    p_flag_follows_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R6: disabling parks the engine
    p_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == LT_OFF && !pulse));

endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer
    import smb_watch_pkg::*;
#(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    input  logic sda_s,
    input  logic tick,
    input  logic start_req,
    output logic bus_free,
    output logic start_go
);

    localparam int            CW  = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

    idle_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          served_q;
    logic          lines_high;

    assign lines_high = scl_s & sda_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IB_BUSY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IB_BUSY: begin
                cnt_d = '0;
                if (en && lines_high) state_d = IB_WAIT;   // settle
            end
            IB_WAIT: begin
                if (!en || !lines_high) begin
                    state_d = IB_BUSY;                     // disable / activity
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == LIM) begin
                        state_d = IB_FREE;                 // expire
                        cnt_d   = SAT;
                    end else begin
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
            end
            IB_FREE: begin
                if (!en || !lines_high) begin
                    state_d = IB_BUSY;                     // disable / activity
                    cnt_d   = '0;
                end else begin
                    cnt_d   = SAT;                         // saturated
                end
            end
            default: begin
                state_d = IB_BUSY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_go <= 1'b0;
            served_q <= 1'b0;
        end else begin
            start_go <= (state_d == IB_FREE) && start_req && !served_q;
            served_q <= start_req && (served_q || (state_d == IB_FREE));
        end
    end

    assign bus_free = (state_q == IB_FREE);

    // R7: the bus only becomes free on a source tick
    p_free_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(tick));

    // R8: free implies both lines were high on the previous edge
    p_free_needs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(lines_high));

    // R9: free persists while idle and enabled
    p_free_persists_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && en && lines_high) |=> bus_free);

    // R10: disabled detection never reports free
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bus_free);

    // R11: the permit lies inside a free period and lasts one cycle
    p_go_inside_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> bus_free);

    p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> !start_go);

endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
    import smb_watch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int IDLE_LIMIT  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             src_tick,
    input  logic             lowto_en,
    input  logic             freeto_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             flag_clr,
    input  logic             start_req,
    output logic             lowto_pulse,
    output logic             lowto_flag,
    output logic             bus_free,
    output logic             start_go
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             scl_s;
    logic             sda_s;

    smb_line_sync #(
        .LINES  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({sda_in, scl_in}),
        .synced (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    smb_low_timer #(
        .CNT_W (CNT_W)
    ) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (lowto_en),
        .scl_s    (scl_s),
        .reload   (reload_val),
        .flag_clr (flag_clr),
        .pulse    (lowto_pulse),
        .flag     (lowto_flag)
    );

    smb_idle_timer #(
        .LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (freeto_en),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .tick      (src_tick),
        .start_req (start_req),
        .bus_free  (bus_free),
        .start_go  (start_go)
    );

    // R1: synchronized lines read the idle level straight out of reset
    p_sync_idle_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (scl_s && sda_s));

endmodule

// File: tb/smb_line_watch_tb.sv
module smb_line_watch_tb;

    localparam int CNT_W = 16;
    localparam int N     = 20;

    logic             clk;
    logic             rst_n;
    logic             scl_in, sda_in, src_tick;
    logic             lowto_en, freeto_en, flag_clr, start_req;
    logic [CNT_W-1:0] reload_val;
    logic             lowto_pulse, lowto_flag, bus_free, start_go;

    smb_line_watch #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .src_tick    (src_tick),
        .lowto_en    (lowto_en),
        .freeto_en   (freeto_en),
        .reload_val  (reload_val),
        .flag_clr    (flag_clr),
        .start_req   (start_req),
        .lowto_pulse (lowto_pulse),
        .lowto_flag  (lowto_flag),
        .bus_free    (bus_free),
        .start_go    (start_go)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef enum int { EV_LOW, EV_FREE, EV_GO } ev_kind_t;
    typedef struct {
        ev_kind_t kind;
        int       at;
        string    tag;
    } ev_t;

    ev_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // Driver side of the scoreboard
    task automatic expect_ev(ev_kind_t k, int at, string tag);
        ev_t e;
        e.kind = k;
        e.at   = at;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor side of the scoreboard
    task automatic match(ev_kind_t k);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected event: actual kind=%0d at cycle %0d expected none", k, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.at != cyc) begin
                errors++;
                $display("FAIL %s event: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                         e.tag, k, cyc, e.kind, e.at);
            end
        end
    endtask

    logic prev_free = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (lowto_pulse)            match(EV_LOW);
            if (bus_free && !prev_free) match(EV_FREE);
            if (start_go)               match(EV_GO);
        end
        prev_free = bus_free;
    end

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic tick_n(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) src_tick = 1'b1;
            @(negedge clk) src_tick = 1'b0;
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int t, v, w;
        rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; src_tick = 1'b0;
        lowto_en = 1'b0; freeto_en = 1'b0; flag_clr = 1'b0; start_req = 1'b0;
        reload_val = CNT_W'(N);
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check(!lowto_pulse && !lowto_flag, "R1", "timeout outputs after reset", {lowto_pulse, lowto_flag}, 0);
        check(!bus_free && !start_go, "R1", "free outputs after reset", {bus_free, start_go}, 0);

        // R2: basic clock-low timeout
        lowto_en = 1'b1;
        idle(3);
        t = cyc;
        scl_in = 1'b0;
        expect_ev(EV_LOW, t + N + 3, "R2");
        idle(N + 10);
        check(lowto_flag, "R5", "flag set by timeout", lowto_flag, 1);
        // R4: long low phase gives no second pulse (monitor flags extras)
        idle(30);
        check(lowto_flag, "R4", "flag still set during long low", lowto_flag, 1);
        scl_in = 1'b1;
        idle(5);
        check(lowto_flag, "R5", "flag sticky after clock rises", lowto_flag, 1);
        clear_flag();
        check(!lowto_flag, "R5", "flag cleared", lowto_flag, 0);

        // R3: stretch of exactly N edges, then a fresh full-length low phase
        t = cyc;
        scl_in = 1'b0;
        idle(N);
        scl_in = 1'b1;
        idle(2);
        t = cyc;
        scl_in = 1'b0;
        expect_ev(EV_LOW, t + N + 3, "R3");
        idle(N + 2);
        check(!lowto_flag, "R3", "no timeout for stretch within limit", lowto_flag, 0);
        idle(3);
        check(lowto_flag, "R3", "restarted count reaches timeout", lowto_flag, 1);
        scl_in = 1'b1;
        idle(3);
        clear_flag();

        // R6: disable and re-enable in the middle of a low phase
        scl_in = 1'b0;
        idle(10);
        lowto_en = 1'b0;
        idle(5);
        v = cyc;
        lowto_en = 1'b1;
        expect_ev(EV_LOW, v + N + 2, "R6");
        idle(N + 1);
        // R5: clear lands on the overflow edge; set wins
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check(lowto_flag, "R5", "set wins over clear", lowto_flag, 1);
        clear_flag();
        lowto_en = 1'b0;
        idle(40);
        check(!lowto_flag, "R6", "no timeout while disabled", lowto_flag, 0);
        scl_in = 1'b1;
        idle(4);

        // R7/R11: bus-free after eleven ticks with a pending START
        start_req = 1'b1;
        t = cyc;
        freeto_en = 1'b1;
        expect_ev(EV_FREE, t + 24, "R7");
        expect_ev(EV_GO,   t + 24, "R11");
        idle(2);
        tick_n(10);
        check(!bus_free, "R7", "not free after ten ticks", bus_free, 0);
        tick_n(1);
        check(bus_free, "R7", "free after eleventh tick", bus_free, 1);
        // R9: saturation
        tick_n(30);
        check(bus_free, "R9", "still free after many ticks", bus_free, 1);

        // R11: request raised while already free
        start_req = 1'b0;
        idle(2);
        w = cyc;
        start_req = 1'b1;
        expect_ev(EV_GO, w + 1, "R11");
        idle(6);
        start_req = 1'b0;

        // R8: START (data low while clock high) drops free
        idle(1);
        sda_in = 1'b0;
        idle(2);
        check(bus_free, "R8", "free before synchronizer delay", bus_free, 1);
        idle(1);
        check(!bus_free, "R8", "free dropped by START", bus_free, 0);
        idle(4);
        sda_in = 1'b1;
        idle(50);
        check(!bus_free, "R7", "no free without ticks", bus_free, 0);
        t = cyc;
        expect_ev(EV_FREE, t + 24, "R8");
        idle(2);
        tick_n(11);
        check(bus_free, "R8", "free again after full recount", bus_free, 1);
        t = cyc;
        scl_in = 1'b0;
        idle(3);
        check(!bus_free, "R8", "clock low drops free", bus_free, 0);
        scl_in = 1'b1;
        idle(4);

        // R10: disable while free, then no free or permit while disabled
        t = cyc;
        expect_ev(EV_FREE, t + 24, "R10");
        idle(2);
        tick_n(11);
        freeto_en = 1'b0;
        idle(1);
        check(!bus_free, "R10", "disable drops free", bus_free, 0);
        start_req = 1'b1;
        tick_n(20);
        check(!bus_free && !start_go, "R10", "quiet while disabled", {bus_free, start_go}, 0);
        start_req = 1'b0;
        idle(5);

        done = 1;
        while (exp_q.size() > 0) begin
            ev_t e;
            e = exp_q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s missing event: actual none expected kind=%0d cycle=%0d", e.tag, e.kind, e.at);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule